// File: doc/BRIEF.md
# Programmable Flag Threshold Register Port

This block holds the two thresholds that a deep FIFO's flag logic compares against the fill level: the almost-empty threshold (n) and the almost-full threshold (m). Each threshold is wider than the 9-bit FIFO data path, so it is kept as a low part of 9 bits and a high part that holds the remaining upper bits. Together these four 9-bit locations are loaded from the FIFO's write data bus on write-clock edges. They can also be read back onto a 9-bit output on read-clock edges.

The block works in one of two modes, picked at reset from the level of the dual-purpose `wen2Ld` pin. If the pin is low during reset, it later acts as a load strobe: while it is low, write and read enables go to the threshold registers, and FIFO traffic is held off. If the pin is high during reset, it acts as a second write enable, and the registers cannot be reached. No address is given. A single rotating position steps through the locations in a fixed order. Both clocks advance it, and it keeps its place from one load session to the next. The assembled thresholds are held steady and passed to both clock domains. They only change while the FIFO is idle.

Top module: `flag_offset_port`

## Requirements
- R1: In load mode, each write-clock edge with `wen2Ld` low and `wen1N` low stores `dataIn` into the location at the current position. The positions run in this order: empty-low (0), empty-high (1), full-low (2), full-high (3). `emptyOffset` is {empty-high, empty-low}, and `fullOffset` is {full-high, full-low}.
- R2: The write after full-high goes back to empty-low.
- R3: When `wen2Ld` is raised in the middle of the sequence, the position is kept. The next access goes to the following location, not to empty-low.
- R4: In load mode, each read-clock edge with `wen2Ld`, `ren1N` and `ren2N` all low puts the location at the current position onto `regData`. It follows the same order and shares the same position as writes. With no such read, `regData` keeps its value.
- R5: Reset sets both low parts to 7 and both high parts to 0, so both offsets read 7. It clears `regData` to 0. It sets `progMode` to the inverse of `wen2Ld` as sampled during reset.
- R6: While load mode is active and `wen2Ld` is low, `fifoWrReq` and `fifoRdReq` stay 0. When `wen2Ld` is high, `fifoWrReq` follows low `wen1N`, and `fifoRdReq` follows both read enables low.
- R7: Each offset is log2(DEPTH) bits wide. A high part stores only `dataIn` bits [log2(DEPTH)-10:0]. It reads back with zeros in the bits above those.
- R8: A reset returns the position to empty-low.
- R9: In two-enable mode (`progMode` = 0), no write or read reaches the registers. `wen2Ld` low blocks `fifoWrReq`, but it does not block `fifoRdReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Active-low reset, sampled on both clocks |
| wen1N | input | 1 | Active-low write enable |
| wen2Ld | input | 1 | Mode strap during reset; afterwards load strobe (active low) or second write enable (active high) |
| ren1N | input | 1 | Active-low read enable 1 |
| ren2N | input | 1 | Active-low read enable 2 |
| dataIn | input | 9 | FIFO write data bus |
| regData | output | 9 | Read-back value of the selected location |
| emptyOffset | output | log2(DEPTH) | Assembled almost-empty threshold n |
| fullOffset | output | log2(DEPTH) | Assembled almost-full threshold m |
| progMode | output | 1 | 1 when load mode was selected at reset |
| fifoWrReq | output | 1 | Qualified write request to the FIFO core |
| fifoRdReq | output | 1 | Qualified read request to the FIFO core |

## Verification
The checker watches several things on every cycle. It checks that the offsets never move without a write access in load mode. It checks that `regData` never moves without a read access. It checks that FIFO requests stay blocked while the load strobe is low. It checks the reset values at the moment reset is released. Some behaviours only the bench scenarios can show. These are the order of the rotating position, the wrap after the fourth location, the position being kept across a raised strobe, and the same position being shared between writes and reads. Also shown only by the bench are the truncation of the high parts and the return to empty-low after a new reset.

// File: rtl/ofs_pkg.sv
`timescale 1ns/1ps
package ofs_pkg;
  // Position codes of the rotating selector; the order is behaviour.
  localparam logic [1:0] SEL_EMPTY_LO = 2'd0;
  localparam logic [1:0] SEL_EMPTY_HI = 2'd1;
  localparam logic [1:0] SEL_FULL_LO  = 2'd2;
  localparam logic [1:0] SEL_FULL_HI  = 2'd3;

  // Strobes from control to datapath.
  typedef struct packed {
    logic       wrStb;  // write-clock domain: store dataIn at sel
    logic       rdStb;  // read-clock domain: load regData from sel
    logic [1:0] sel;    // current rotating position
  } ofsStrobe_t;
endpackage

// File: rtl/ofs_access_ctrl.sv
`timescale 1ns/1ps
module ofs_access_ctrl
  import ofs_pkg::*;
(
  input  logic       wrClk,
  input  logic       rdClk,
  input  logic       rstN,
  input  logic       wen1N,
  input  logic       wen2Ld,
  input  logic       ren1N,
  input  logic       ren2N,
  output logic       progMode,
  output logic       fifoWrReq,
  output logic       fifoRdReq,
  output ofsStrobe_t stb
);
  logic [1:0] wrCnt;
  logic [1:0] rdCnt;
  logic       loadOpen;

  // Mode strap: sampled on every write edge while reset is held.
  always_ff @(posedge wrClk) begin
    if (!rstN) progMode <= ~wen2Ld;
  end

  assign loadOpen = rstN & progMode & ~wen2Ld;

  always_comb begin
    stb.wrStb = loadOpen & ~wen1N;
    stb.rdStb = loadOpen & ~ren1N & ~ren2N;
    stb.sel   = wrCnt + rdCnt;  // shared position, each side adds its own steps
  end

  always_ff @(posedge wrClk) begin
    if (!rstN)          wrCnt <= '0;
    else if (stb.wrStb) wrCnt <= wrCnt + 2'd1;
  end

  always_ff @(posedge rdClk) begin
    if (!rstN)          rdCnt <= '0;
    else if (stb.rdStb) rdCnt <= rdCnt + 2'd1;
  end

  assign fifoWrReq = rstN & ~wen1N & wen2Ld;
  assign fifoRdReq = rstN & ~ren1N & ~ren2N & ~(progMode & ~wen2Ld);
endmodule

// File: rtl/ofs_regfile.sv
`timescale 1ns/1ps
module ofs_regfile
  import ofs_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic [8:0]    dataIn,
  input  ofsStrobe_t    stb,
  output logic [8:0]    regData,
  output logic [AW-1:0] emptyOffset,
  output logic [AW-1:0] fullOffset
);
  localparam int  LO_W   = 9;
  localparam bit  HAS_HI = (AW > LO_W);
  localparam int  HI_W   = HAS_HI ? AW - LO_W : 1;
  localparam logic [8:0] LO_RESET = 9'h007;

  logic [8:0]    loVal  [2];
  logic [8:0]    hiVal  [2];
  logic [AW-1:0] ofsVal [2];

  // Index 0 = empty threshold, index 1 = full threshold.
  for (genvar g = 0; g < 2; g++) begin : gen_ofs
    logic [8:0] lo;
    always_ff @(posedge wrClk) begin
      if (!rstN) lo <= LO_RESET;
      else if (stb.wrStb && stb.sel == 2'(2 * g)) lo <= dataIn;
    end
    assign loVal[g] = lo;

    if (HAS_HI) begin : gen_hi
      logic [HI_W-1:0] hi;
      always_ff @(posedge wrClk) begin
        if (!rstN) hi <= '0;
        else if (stb.wrStb && stb.sel == 2'(2 * g + 1)) hi <= dataIn[HI_W-1:0];
      end
      assign hiVal[g]  = 9'(hi);
      assign ofsVal[g] = {hi, lo};
    end else begin : gen_no_hi
      assign hiVal[g]  = 9'h000;
      assign ofsVal[g] = lo[AW-1:0];
    end
  end

  assign emptyOffset = ofsVal[0];
  assign fullOffset  = ofsVal[1];

  always_ff @(posedge rdClk) begin
    if (!rstN) regData <= '0;
    else if (stb.rdStb) regData <= stb.sel[0] ? hiVal[stb.sel[1]] : loVal[stb.sel[1]];
  end
endmodule

// File: rtl/flag_offset_port.sv
`timescale 1ns/1ps
module flag_offset_port
  import ofs_pkg::*;
#(
  parameter int DEPTH = 16384
) (
  input  logic                     wrClk,
  input  logic                     rdClk,
  input  logic                     rstN,
  input  logic                     wen1N,
  input  logic                     wen2Ld,
  input  logic                     ren1N,
  input  logic                     ren2N,
  input  logic [8:0]               dataIn,
  output logic [8:0]               regData,
  output logic [$clog2(DEPTH)-1:0] emptyOffset,
  output logic [$clog2(DEPTH)-1:0] fullOffset,
  output logic                     progMode,
  output logic                     fifoWrReq,
  output logic                     fifoRdReq
);
  localparam int AW = $clog2(DEPTH);

  ofsStrobe_t stb;

  ofs_access_ctrl i_ctrl (
    .wrClk     (wrClk),
    .rdClk     (rdClk),
    .rstN      (rstN),
    .wen1N     (wen1N),
    .wen2Ld    (wen2Ld),
    .ren1N     (ren1N),
    .ren2N     (ren2N),
    .progMode  (progMode),
    .fifoWrReq (fifoWrReq),
    .fifoRdReq (fifoRdReq),
    .stb       (stb)
  );

  ofs_regfile #(.AW(AW)) i_regs (
    .wrClk       (wrClk),
    .rdClk       (rdClk),
    .rstN        (rstN),
    .dataIn      (dataIn),
    .stb         (stb),
    .regData     (regData),
    .emptyOffset (emptyOffset),
    .fullOffset  (fullOffset)
  );
endmodule

// File: rtl/flag_offset_port_chk.sv
`timescale 1ns/1ps
module flag_offset_port_chk #(
  parameter int AW = 14
) (
  input logic          wrClk,
  input logic          rdClk,
  input logic          rstN,
  input logic          wen1N,
  input logic          wen2Ld,
  input logic          ren1N,
  input logic          ren2N,
  input logic [8:0]    regData,
  input logic [AW-1:0] emptyOffset,
  input logic [AW-1:0] fullOffset,
  input logic          progMode,
  input logic          fifoWrReq,
  input logic          fifoRdReq
);
  AST_RESET_DEFAULTS: assert property (@(posedge wrClk) disable iff (!rstN)
    $rose(rstN) |-> (emptyOffset == AW'(7) && fullOffset == AW'(7))); // R5

  AST_OFFSETS_HOLD: assert property (@(posedge wrClk) disable iff (!rstN)
    !(progMode && !wen2Ld && !wen1N) |=> ($stable(emptyOffset) && $stable(fullOffset))); // R9

  AST_READBACK_HOLD: assert property (@(posedge rdClk) disable iff (!rstN)
    !(progMode && !wen2Ld && !ren1N && !ren2N) |=> $stable(regData)); // R4

  AST_NO_FIFO_READ_IN_LOAD: assert property (@(posedge rdClk) disable iff (!rstN)
    (progMode && !wen2Ld) |-> !fifoRdReq); // R6

  AST_NO_FIFO_WRITE_IN_LOAD: assert property (@(posedge wrClk) disable iff (!rstN)
    !wen2Ld |-> !fifoWrReq); // R6
endmodule

bind flag_offset_port flag_offset_port_chk #(.AW($clog2(DEPTH))) i_chk (
  .wrClk       (wrClk),
  .rdClk       (rdClk),
  .rstN        (rstN),
  .wen1N       (wen1N),
  .wen2Ld      (wen2Ld),
  .ren1N       (ren1N),
  .ren2N       (ren2N),
  .regData     (regData),
  .emptyOffset (emptyOffset),
  .fullOffset  (fullOffset),
  .progMode    (progMode),
  .fifoWrReq   (fifoWrReq),
  .fifoRdReq   (fifoRdReq)
);

// File: tb/test_flag_offset_port.sv
`timescale 1ns/1ps
module test_flag_offset_port;
  localparam int DEPTH = 16384;
  localparam int AW    = $clog2(DEPTH);

  logic wrClk = 1'b0;
  logic rdClk;
  logic rstN = 1'b0, wen1N = 1'b1, wen2Ld = 1'b0, ren1N = 1'b1, ren2N = 1'b1;
  logic [8:0] dataIn = '0;
  logic [8:0] regData;
  logic [AW-1:0] emptyOffset, fullOffset;
  logic progMode, fifoWrReq, fifoRdReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 wrClk = ~wrClk;   // 250 MHz
  assign rdClk = ~wrClk;      // same rate, half a period apart

  flag_offset_port #(.DEPTH(DEPTH)) i_flag_offset_port (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wen1N(wen1N), .wen2Ld(wen2Ld),
    .ren1N(ren1N), .ren2N(ren2N), .dataIn(dataIn), .regData(regData),
    .emptyOffset(emptyOffset), .fullOffset(fullOffset), .progMode(progMode),
    .fifoWrReq(fifoWrReq), .fifoRdReq(fifoRdReq)
  );

  // Vector: op[38:37] (0 write, 1 read, 2 check offsets, 3 strobe break),
  // data[36:28], expA[27:14] (regData or emptyOffset), expB[13:0] (fullOffset).
  localparam int NV = 19;
  localparam logic [38:0] VEC [NV] = '{
    {2'd0, 9'h010, 14'h0000, 14'h0000},
    {2'd0, 9'h003, 14'h0000, 14'h0000},
    {2'd0, 9'h020, 14'h0000, 14'h0000},
    {2'd0, 9'h001, 14'h0000, 14'h0000},
    {2'd2, 9'h000, 14'h0610, 14'h0220},
    {2'd1, 9'h000, 14'h0010, 14'h0000},
    {2'd1, 9'h000, 14'h0003, 14'h0000},
    {2'd1, 9'h000, 14'h0020, 14'h0000},
    {2'd1, 9'h000, 14'h0001, 14'h0000},
    {2'd0, 9'h0AA, 14'h0000, 14'h0000},
    {2'd2, 9'h000, 14'h06AA, 14'h0220},
    {2'd3, 9'h000, 14'h0000, 14'h0000},
    {2'd0, 9'h1FF, 14'h0000, 14'h0000},
    {2'd2, 9'h000, 14'h3EAA, 14'h0220},
    {2'd3, 9'h000, 14'h0000, 14'h0000},
    {2'd1, 9'h000, 14'h0020, 14'h0000},
    {2'd1, 9'h000, 14'h0001, 14'h0000},
    {2'd1, 9'h000, 14'h00AA, 14'h0000},
    {2'd1, 9'h000, 14'h001F, 14'h0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic resetDut(input logic strap);
    @(posedge wrClk); #1;
    rstN = 1'b0; wen2Ld = strap; wen1N = 1'b1; ren1N = 1'b1; ren2N = 1'b1;
    repeat (4) @(posedge wrClk);
    #1 rstN = 1'b1;
  endtask

  task automatic doWrite(input logic [8:0] d);
    @(posedge wrClk); #1;
    dataIn = d; wen1N = 1'b0;
    @(posedge wrClk); #1;
    wen1N = 1'b1;
  endtask

  task automatic doRead();
    @(posedge rdClk); #1;
    ren1N = 1'b0; ren2N = 1'b0;
    @(posedge rdClk); #1;
    ren1N = 1'b1; ren2N = 1'b1;
  endtask

  task automatic strobeBreak();
    @(posedge wrClk); #1 wen2Ld = 1'b1;
    @(posedge wrClk); @(posedge rdClk); #1 wen2Ld = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    // R5: reset state in load mode
    resetDut(1'b0);
    check("R5 progMode", progMode, 1);
    check("R5 emptyOffset default", emptyOffset, 7);
    check("R5 fullOffset default", fullOffset, 7);
    check("R5 regData cleared", regData, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      op = VEC[i][38:37];
      case (op)
        2'd0: doWrite(VEC[i][36:28]);
        2'd1: begin
          doRead();
          check("R4 readback order", regData, 32'(VEC[i][22:14]));
        end
        2'd2: begin
          check("R1 R2 R3 R7 emptyOffset", emptyOffset, 32'(VEC[i][27:14]));
          check("R1 R2 R3 R7 fullOffset", fullOffset, 32'(VEC[i][13:0]));
        end
        default: strobeBreak();
      endcase
    end

    // R6: FIFO requests blocked while the load strobe is low
    @(posedge wrClk); #1 wen1N = 1'b0;
    #0.5 check("R6 write blocked in load", fifoWrReq, 0);
    wen1N = 1'b1; ren1N = 1'b0; ren2N = 1'b0;
    #0.5 check("R6 read blocked in load", fifoRdReq, 0);
    ren1N = 1'b1; ren2N = 1'b1; wen2Ld = 1'b1;
    @(posedge wrClk); #1 wen1N = 1'b0; ren1N = 1'b0; ren2N = 1'b0;
    #0.5 check("R6 write passes", fifoWrReq, 1);
    check("R6 read passes", fifoRdReq, 1);
    wen1N = 1'b1; ren1N = 1'b1; ren2N = 1'b1; wen2Ld = 1'b0;

    // R8: new reset returns position to empty-low, defaults reload
    resetDut(1'b0);
    doRead(); check("R8 first read empty-low", regData, 9'h007);
    doRead(); check("R8 second read empty-high", regData, 9'h000);
    doRead(); check("R8 third read full-low", regData, 9'h007);
    doRead(); check("R8 fourth read full-high", regData, 9'h000);

    // R9: two-enable mode, no register access
    resetDut(1'b1);
    check("R9 progMode", progMode, 0);
    @(posedge wrClk); #1 wen2Ld = 1'b0; wen1N = 1'b0; dataIn = 9'h055;
    #0.5 check("R9 wen2 low blocks write", fifoWrReq, 0);
    @(posedge wrClk); #1 wen1N = 1'b1;
    check("R9 emptyOffset untouched", emptyOffset, 7);
    check("R9 fullOffset untouched", fullOffset, 7);
    @(posedge rdClk); #1 ren1N = 1'b0; ren2N = 1'b0;
    #0.5 check("R9 read still reaches FIFO", fifoRdReq, 1);
    @(posedge rdClk); #1 ren1N = 1'b1; ren2N = 1'b1;
    check("R9 regData untouched", regData, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule